// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Controller with I2C Target

This block is an I2C target that sits in front of the small register file of a single-channel digital potentiometer. A bus controller addresses it at seven-bit address 0101000, sets a register pointer, and then writes or reads data bytes. After each data byte the pointer advances by one. The block drives an 8-bit wiper position straight from its volatile wiper register.

Location 00h is mapped to two registers. Bit 7 of the mode register at 08h selects which one is used. With the bit clear, a write to 00h updates both the volatile wiper and the non-volatile start-up value, and a read returns the start-up value. With the bit set, a write updates only the wiper, and a read returns the wiper. The non-volatile register is modelled as a flop. A busy flag stays high for a parameterised number of clock cycles to stand for the programming time. After a non-volatile write, the block refuses every further data byte in that transaction. Location 01h holds a fixed identification byte.

SCL and SDA arrive as raw samples. They are synchronised, and START and STOP are detected from SDA edges while SCL is high. SDA is driven through an open-drain enable. The block has no streaming data interface and no back-pressure: bytes move at the pace of the bus clock, and the target never stretches SCL.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: The block ACKs the address byte 50h (write) or 51h (read). It NACKs any other address byte, then NACKs every following byte of that transaction and changes no register. SDA is released whenever the block is not acknowledging or sending a 0.
- R2: In a write transaction, the first byte after the address sets the pointer. Each following data byte is ACKed, stored at the pointer, and then the pointer advances by one with 8-bit wrap.
- R3: A read of location 01h returns D0h. A write to 01h is ACKed and changes nothing.
- R4: Location 08h is a read/write mode register that resets to 00h. Its bit 7 selects volatile mode when it is 1.
- R5: With mode bit 7 at 0, a write to 00h loads both the wiper and the start-up value register. A read of 00h returns the start-up value.
- R6: With mode bit 7 at 1, a write to 00h loads only the wiper and starts no busy period. A read of 00h returns the wiper.
- R7: The wiper output follows the wiper register one clock after the write strobe, including while the busy flag is high.
- R8: After reset, the wiper output and the start-up value are both 80h, the mode register is 00h, the busy flag is low and SDA is released.
- R9: A non-volatile write raises the busy flag for exactly NV_WRITE_CYCLES clock cycles. Every later data byte in the same transaction is NACKed and not stored.
- R10: A read transaction sends the byte at the pointer MSB first and then advances the pointer. It keeps sending while the controller ACKs and stops after a NACK.
- R11: A repeated START restarts address decoding at any point and keeps the pointer.
- R12: Locations other than 00h, 01h and 08h ACK writes and ignore them, and they read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line sample |
| sda_i | input | 1 | Raw SDA line sample |
| sda_oe_o | output | 1 | When 1, pull SDA low (open drain) |
| wiper_o | output | 8 | Wiper position |
| nv_busy_o | output | 1 | Non-volatile programming in progress |

## Verification
The hardest situation to reach is the non-volatile lock. To reach it, mode bit 7 must be clear and a second data byte must follow a write to 00h inside the same transaction. The stimulus first writes the mode register through the bus, then sends a two-byte burst at pointer 00h. It expects an ACK for the first byte and a NACK for the second. The length of the busy pulse that follows is measured in clock cycles.

// File: rtl/wiper_ctrl_pkg.sv
package wiper_ctrl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_RACK
  } phase_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } byte_kind_e;

  localparam logic [BYTE_W-1:0] LOC_DIAL     = 8'h00;
  localparam logic [BYTE_W-1:0] LOC_IDENT    = 8'h01;
  localparam logic [BYTE_W-1:0] LOC_MODE     = 8'h08;
  localparam logic [BYTE_W-1:0] IDENT_VALUE  = 8'hD0;
  localparam logic [BYTE_W-1:0] DIAL_DEFAULT = 8'h80;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_regmap.sv
module wiper_regmap
  import wiper_ctrl_pkg::*;
#(
  parameter int NV_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              vol_mode,
  output logic [BYTE_W-1:0] wiper_o,
  output logic              nv_busy_o
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);

  logic [BYTE_W-1:0] dial_q, init_q, mode_q;
  logic [CNT_W-1:0]  busy_cnt;
  logic              nv_wr;

  assign vol_mode = mode_q[BYTE_W-1];
  assign nv_wr    = wr_en && (wr_addr == LOC_DIAL) && !vol_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= DIAL_DEFAULT;
      dial_q   <= DIAL_DEFAULT;
      mode_q   <= '0;
      busy_cnt <= '0;
    end else begin
      if (wr_en && wr_addr == LOC_DIAL) dial_q <= wr_data;
      if (wr_en && wr_addr == LOC_MODE) mode_q <= wr_data;
      if (nv_wr) begin
        init_q   <= wr_data;
        busy_cnt <= CNT_W'(NV_CYCLES);
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      LOC_DIAL:  rd_data = vol_mode ? dial_q : init_q;
      LOC_IDENT: rd_data = IDENT_VALUE;
      LOC_MODE:  rd_data = mode_q;
      default:   rd_data = '0;
    endcase
  end

  assign wiper_o   = dial_q;
  assign nv_busy_o = (busy_cnt != '0);
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import wiper_ctrl_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              vol_mode,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_addr
);
  phase_e            phase_q;
  byte_kind_e        kind_q;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, txreg, ptr_q;
  logic              rx_full, ack_q, is_read, nv_lock, ctl_ack;
  logic              dial_nv;

  assign dial_nv = (ptr_q == LOC_DIAL) && !vol_mode;
  assign wr_en   = !start_evt && !stop_evt && phase_q == PH_RX && rx_full &&
                   scl_fall && kind_q == BY_DATA && !nv_lock;
  assign wr_addr = ptr_q;
  assign wr_data = shreg;
  assign rd_addr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= BY_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      txreg   <= '0;
      ptr_q   <= '0;
      rx_full <= 1'b0;
      ack_q   <= 1'b0;
      is_read <= 1'b0;
      nv_lock <= 1'b0;
      ctl_ack <= 1'b0;
    end else if (start_evt) begin
      phase_q <= PH_RX;
      kind_q  <= BY_ADDR;
      bit_cnt <= '0;
      rx_full <= 1'b0;
      ack_q   <= 1'b0;
      nv_lock <= 1'b0;
    end else if (stop_evt) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && !rx_full) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) rx_full <= 1'b1;
          end else if (scl_fall && rx_full) begin
            rx_full <= 1'b0;
            phase_q <= PH_ACK;
            unique case (kind_q)
              BY_ADDR: begin
                ack_q   <= (shreg[BYTE_W-1:1] == TARGET_ADDR);
                is_read <= shreg[0];
              end
              BY_PTR: begin
                ack_q <= 1'b1;
                ptr_q <= shreg;
              end
              default: begin
                ack_q <= !nv_lock;
                if (!nv_lock) begin
                  if (dial_nv) nv_lock <= 1'b1;
                  else         ptr_q   <= ptr_q + 8'd1;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            ack_q   <= 1'b0;
            bit_cnt <= '0;
            if (!ack_q) begin
              phase_q <= PH_IDLE;
            end else if (kind_q == BY_ADDR && is_read) begin
              phase_q <= PH_TX;
              txreg   <= rd_data;
              ptr_q   <= ptr_q + 8'd1;
            end else begin
              phase_q <= PH_RX;
              kind_q  <= (kind_q == BY_ADDR) ? BY_PTR : BY_DATA;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              phase_q <= PH_RACK;
            end else begin
              txreg   <= {txreg[BYTE_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) ctl_ack <= !sda_s;
          if (scl_fall) begin
            if (ctl_ack) begin
              phase_q <= PH_TX;
              bit_cnt <= '0;
              txreg   <= rd_data;
              ptr_q   <= ptr_q + 8'd1;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_ACK:  sda_oe = ack_q;
      PH_TX:   sda_oe = !txreg[BYTE_W-1];
      default: sda_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wiper_ctrl_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR     = 7'h28,
  parameter int         NV_WRITE_CYCLES = 1000,
  parameter int         SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] wiper_o,
  output logic       nv_busy_o
);
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en, vol_mode;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_target_engine #(.TARGET_ADDR(TARGET_ADDR)) eng_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .vol_mode(vol_mode), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
  );

  wiper_regmap #(.NV_CYCLES(NV_WRITE_CYCLES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .vol_mode(vol_mode), .wiper_o(wiper_o), .nv_busy_o(nv_busy_o)
  );
endmodule

// File: rtl/wiper_i2c_chk.sv
module wiper_i2c_chk
  import wiper_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        wiper_o,
  input logic              nv_busy_o,
  input logic              sda_oe_o,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_addr,
  input logic              vol_mode,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt
);
  // R7: the wiper moves only right after a write strobe
  assert_wiper_from_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_o) |-> $past(wr_en));

  // R12: writes away from 00h leave the wiper alone
  assert_other_loc_keeps_wiper_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != LOC_DIAL) |=> $stable(wiper_o));

  // R9: a non-volatile write raises busy on the next cycle
  assert_nv_write_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LOC_DIAL && !vol_mode) |=> nv_busy_o);

  // R9: busy only starts after a non-volatile write
  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy_o) |-> $past(wr_en && wr_addr == LOC_DIAL && !vol_mode));

  // R6: a volatile write starts no busy period
  assert_vol_write_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LOC_DIAL && vol_mode && !nv_busy_o) |=> !nv_busy_o);

  // R1: SDA drive changes only on an SCL fall or a bus condition
  assert_sda_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_evt || stop_evt));
endmodule

bind wiper_i2c_ctrl wiper_i2c_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wiper_o(wiper_o), .nv_busy_o(nv_busy_o),
  .sda_oe_o(sda_oe_o), .wr_en(wr_en), .wr_addr(wr_addr),
  .vol_mode(vol_mode), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt)
);

// File: tb/wiper_i2c_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_i2c_ctrl_tb_top;
  localparam int NV  = 40;
  localparam int Q   = 8;
  localparam int NV_ = 10;
  // {pointer, data written, expected readback, expected wiper}
  localparam logic [31:0] VEC [NV_] = '{
    32'h08_80_80_80, 32'h00_3C_3C_3C, 32'h01_55_D0_3C, 32'h05_77_00_3C,
    32'h08_00_00_3C, 32'h00_A5_A5_A5, 32'h08_80_80_A5, 32'h00_11_11_11,
    32'h08_00_00_11, 32'h01_00_D0_11
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe, busy, sda_line;
  logic [7:0] wiper;
  int checks = 0, errors = 0, run = 0, last_len = 0;

  always #5 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  wiper_i2c_ctrl #(.NV_WRITE_CYCLES(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wiper_o(wiper), .nv_busy_o(busy)
  );

  always @(posedge clk) begin
    if (busy) run = run + 1;
    else if (run != 0) begin last_len = run; run = 0; end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart();
    w(Q); m_low = 1'b0; w(Q); scl = 1'b1; w(Q); m_low = 1'b1; w(Q); scl = 1'b0;
  endtask
  task automatic bstop();
    w(Q); m_low = 1'b1; w(Q); scl = 1'b1; w(Q); m_low = 1'b0; w(Q);
  endtask
  task automatic send_bit(input logic b);
    w(Q); m_low = !b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0;
  endtask
  task automatic recv_bit(output logic b);
    w(Q); m_low = 1'b0; w(Q); scl = 1'b1; w(Q); b = sda_line; w(Q); scl = 1'b0;
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask
  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(!give_ack);
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bstart();
    wbyte(8'h50, a); chk("R1 write address ack", {7'd0, a}, 8'd1);
    wbyte(p, a);     chk("R2 pointer ack", {7'd0, a}, 8'd1);
    wbyte(d, a);     chk("R2 data ack", {7'd0, a}, 8'd1);
    bstop();
  endtask

  task automatic reg_read(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bstart();
    wbyte(8'h50, a); chk("R1 address ack", {7'd0, a}, 8'd1);
    wbyte(p, a);     chk("R2 pointer ack", {7'd0, a}, 8'd1);
    bstart();
    wbyte(8'h51, a); chk("R11 read address after repeated start", {7'd0, a}, 8'd1);
    rbyte(1'b0, d);
    bstop();
  endtask

  initial begin
    logic [7:0] d;
    logic a;
    w(5); rst_n = 1'b1; w(5);
    // R8 reset state
    chk("R8 wiper reset", wiper, 8'h80);
    chk("R8 busy reset", {7'd0, busy}, 8'd0);
    chk("R8 sda released", {7'd0, sda_oe}, 8'd0);
    reg_read(8'h00, d); chk("R8 start-up value read", d, 8'h80);
    reg_read(8'h08, d); chk("R4 mode reset", d, 8'h00);

    // R1 foreign address
    bstart();
    wbyte(8'h52, a); chk("R1 foreign address nack", {7'd0, a}, 8'd0);
    wbyte(8'h00, a); chk("R1 byte after foreign address", {7'd0, a}, 8'd0);
    wbyte(8'h33, a); chk("R1 data after foreign address", {7'd0, a}, 8'd0);
    bstop();
    chk("R1 wiper untouched", wiper, 8'h80);

    // vector table: R3 R4 R5 R6 R12
    for (int i = 0; i < NV_; i++) begin
      reg_write(VEC[i][31:24], VEC[i][23:16]);
      reg_read(VEC[i][31:24], d);
      chk("R3 R4 R5 R6 R12 vector readback", d, VEC[i][15:8]);
      chk("R7 vector wiper", wiper, VEC[i][7:0]);
    end

    // R5 mode 0 read of 00h returns start-up value, not wiper
    reg_read(8'h00, d); chk("R5 read returns start-up value", d, 8'hA5);
    chk("R5 wiper differs", wiper, 8'h11);

    // R9 lock after non-volatile write
    while (busy) w(1);
    bstart();
    wbyte(8'h50, a); wbyte(8'h00, a);
    wbyte(8'h22, a); chk("R9 first nv byte ack", {7'd0, a}, 8'd1);
    chk("R9 busy during programming", {7'd0, busy}, 8'd1);
    chk("R7 wiper moves during busy", wiper, 8'h22);
    wbyte(8'h33, a); chk("R9 later byte nack", {7'd0, a}, 8'd0);
    bstop();
    chk("R9 later byte not stored", wiper, 8'h22);
    while (busy) w(1);
    w(2);
    chk("R9 busy length", last_len[7:0], NV[7:0]);
    reg_read(8'h00, d); chk("R9 start-up value", d, 8'h22);

    // R2 multi-byte write with increment
    bstart();
    wbyte(8'h50, a); wbyte(8'h07, a);
    wbyte(8'h01, a); chk("R12 unmapped write ack", {7'd0, a}, 8'd1);
    wbyte(8'h80, a); chk("R2 incremented write ack", {7'd0, a}, 8'd1);
    wbyte(8'h44, a); chk("R2 third byte ack", {7'd0, a}, 8'd1);
    bstop();
    reg_read(8'h08, d); chk("R2 second byte landed at 08h", d, 8'h80);
    bstart();
    wbyte(8'h50, a); wbyte(8'h00, a);
    wbyte(8'h5A, a); chk("R6 volatile ack", {7'd0, a}, 8'd1);
    wbyte(8'h66, a); chk("R6 no lock in volatile mode", {7'd0, a}, 8'd1);
    bstop();
    chk("R6 wiper", wiper, 8'h5A);
    chk("R6 no busy", {7'd0, busy}, 8'd0);

    // R10 burst read across locations
    bstart();
    wbyte(8'h50, a); wbyte(8'h00, a);
    bstart();
    wbyte(8'h51, a); chk("R11 repeated start address", {7'd0, a}, 8'd1);
    rbyte(1'b1, d); chk("R10 byte at 00h", d, 8'h5A);
    rbyte(1'b1, d); chk("R10 byte at 01h", d, 8'hD0);
    rbyte(1'b1, d); chk("R10 byte at 02h", d, 8'h00);
    rbyte(1'b0, d); chk("R10 byte at 03h", d, 8'h00);
    bstop();
    bstart();
    wbyte(8'h50, a); wbyte(8'h07, a);
    bstart();
    wbyte(8'h51, a);
    rbyte(1'b1, d); chk("R10 byte at 07h", d, 8'h00);
    rbyte(1'b0, d); chk("R10 byte at 08h", d, 8'h80);
    bstop();
    chk("R10 bus released after nack", {7'd0, sda_oe}, 8'd0);

    // R8 reset again
    rst_n = 1'b0; w(3); rst_n = 1'b1; w(3);
    chk("R8 wiper after reset", wiper, 8'h80);
    reg_read(8'h08, d); chk("R8 mode after reset", d, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule